// File: doc/BRIEF.md
# Hash Join Bit-Vector Filter

This block is the on-chip front end of a two-phase equi-join. It has a build phase and a probe phase. In the build phase it takes join-key/row-address pairs from the smaller table, one per cycle and with no stall. For each key it computes a hash, sets the bit that hash selects in a filter bit vector, and appends the key and address to an address table. Entries that share a hash bucket form a linked list, with the newest entry at the head.

In the probe phase it takes keys from the larger table. A key whose filter bit is clear is dropped at once, without reading the table. A key whose bit is set starts a walk along its bucket list, one entry per cycle, and input is stalled for the whole walk. Each entry on the list whose stored key equals the probe key puts its row address on the match output for one cycle. A filter bit can be shared by different keys, so every candidate entry is confirmed by a full key comparison.

A synchronous clear command empties the filter and the bucket lists, so the block is ready for a new join.

Top module: `hjoin_filter`

## Requirements
- R1: After reset or a clear, `in_ready_o` is 1, `match_valid_o` is 0, and every probe key is dropped with no stall and no match.
- R2: The filter index is the XOR fold of the key into `FILT_W`-bit slices, where key bit i feeds index bit (i mod `FILT_W`). The bucket index is the low `HASH_W` bits of the filter index. Both phases use this same function.
- R3: With `phase_i`=0, a row is accepted in every cycle that has `in_valid_i` high, and `in_ready_o` stays 1. Each accepted row sets its filter bit. It also stores its key and row address, as long as fewer than `DEPTH` entries are held.
- R4: With `phase_i`=1, a key whose filter bit is clear gives no match, and `in_ready_o` is still 1 in the next cycle.
- R5: With `phase_i`=1, a key whose filter bit is set holds `in_ready_o` low for exactly as many cycles as its bucket list has entries. An empty list gives zero cycles.
- R6: During a walk, each stored entry whose key equals the probe key gives one cycle of `match_valid_o` with that entry's row address. Matches come newest-inserted first. The first match appears two cycles after the probe key is accepted.
- R7: A bucket entry with a different key, whether it reaches the walk through a shared filter bit or a shared bucket, gives no match.
- R8: Once `DEPTH` entries are held, further build rows are not stored and never match. Their filter bits are still set.
- R9: `clear_i` overrides everything else. It ends a walk in progress and discards the input offered in that cycle. One cycle later `in_ready_o` is 1 and `match_valid_o` is 0.
- R10: `phase_i`, `in_key_i` and `in_row_i` are used only in a cycle where the input is accepted. Input offered while `in_ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of filter and bucket lists |
| phase_i | input | 1 | 0 = build, 1 = probe; sampled on acceptance |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Block can accept a row |
| in_key_i | input | KEY_W | Join key |
| in_row_i | input | ROW_W | Row address (build phase) |
| match_valid_o | output | 1 | One match on this cycle |
| match_row_o | output | ROW_W | Row address of the matching stored entry |

## Verification
The assertions rely on the filter lookup being driven from the key on the input that same cycle. They also rely on `clear_i` never coinciding with reset release. Beyond that, they accept any legal pattern of input and phase changes.

The stimulus changes inputs only at falling edges. It drops `in_valid_i` after each probe and then waits for `in_ready_o` before offering the next key. It also offers one deliberate input while `in_ready_o` is low, to exercise R10. A mid-walk clear is raised only after a probe has been accepted, so R9 is checked against a walk that is really in progress.

// File: rtl/hjf_pkg.sv
package hjf_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/hjf_hash.sv
module hjf_hash #(
  parameter int KEY_W  = 16,
  parameter int FILT_W = 6,
  parameter int HASH_W = 4
) (
  input  logic [KEY_W-1:0]  key_i,
  output logic [FILT_W-1:0] filt_idx_o,
  output logic [HASH_W-1:0] bucket_o
);
  localparam int SLICES = (KEY_W + FILT_W - 1) / FILT_W;
  localparam int PAD_W  = SLICES * FILT_W;

  logic [PAD_W-1:0] key_pad;
  assign key_pad = PAD_W'(key_i);

  always_comb begin
    filt_idx_o = '0;
    for (int s = 0; s < SLICES; s++) begin
      filt_idx_o = filt_idx_o ^ key_pad[s*FILT_W +: FILT_W];
    end
  end

  assign bucket_o = filt_idx_o[HASH_W-1:0];
endmodule

// File: rtl/hjf_bitvec.sv
module hjf_bitvec #(
  parameter int FILT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              set_i,
  input  logic [FILT_W-1:0] idx_i,
  output logic              hit_o
);
  localparam int BITS = 1 << FILT_W;

  logic [BITS-1:0] bits_q;

  for (genvar g = 0; g < BITS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_q[g] <= 1'b0;
      end else if (clear_i) begin
        bits_q[g] <= 1'b0;
      end else if (set_i && (idx_i == FILT_W'(g))) begin
        bits_q[g] <= 1'b1;
      end
    end
  end

  assign hit_o = bits_q[idx_i];
endmodule

// File: rtl/hjf_table.sv
module hjf_table #(
  parameter int KEY_W  = 16,
  parameter int ROW_W  = 16,
  parameter int HASH_W = 4,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ins_i,
  input  logic [HASH_W-1:0] bucket_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [PTR_W-1:0]  head_o,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [KEY_W-1:0]  rd_key_o,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic [PTR_W-1:0]  rd_next_o
);
  localparam int BUCKETS = 1 << HASH_W;
  localparam logic [PTR_W-1:0] NULL_PTR = '1;
  localparam logic [PTR_W-1:0] DEPTH_P  = PTR_W'(DEPTH);

  logic [PTR_W-1:0] head_q [BUCKETS];
  logic [KEY_W-1:0] key_q  [DEPTH];
  logic [ROW_W-1:0] row_q  [DEPTH];
  logic [PTR_W-1:0] next_q [DEPTH];
  logic [PTR_W-1:0] count_q;
  logic             ins_ok;

  assign ins_ok = ins_i && (count_q != DEPTH_P) && !clear_i;
  assign head_o = head_q[bucket_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (ins_ok) begin
      count_q <= count_q + 1'b1;
    end
  end

  for (genvar b = 0; b < BUCKETS; b++) begin : g_head
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        head_q[b] <= NULL_PTR;
      end else if (clear_i) begin
        head_q[b] <= NULL_PTR;
      end else if (ins_ok && (bucket_i == HASH_W'(b))) begin
        head_q[b] <= count_q;
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q[e]  <= '0;
        row_q[e]  <= '0;
        next_q[e] <= NULL_PTR;
      end else if (ins_ok && (count_q == PTR_W'(e))) begin
        key_q[e]  <= key_i;
        row_q[e]  <= row_i;
        next_q[e] <= head_q[bucket_i];
      end
    end
  end

  assign rd_key_o  = key_q[rd_ptr_i[IDX_W-1:0]];
  assign rd_row_o  = row_q[rd_ptr_i[IDX_W-1:0]];
  assign rd_next_o = next_q[rd_ptr_i[IDX_W-1:0]];
endmodule

// File: rtl/hjoin_filter.sv
module hjoin_filter #(
  parameter int KEY_W  = 16,
  parameter int ROW_W  = 16,
  parameter int FILT_W = 6,
  parameter int HASH_W = 4,
  parameter int DEPTH  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             phase_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [KEY_W-1:0] in_key_i,
  input  logic [ROW_W-1:0] in_row_i,
  output logic             match_valid_o,
  output logic [ROW_W-1:0] match_row_o
);
  import hjf_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  walk_st_e         state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [KEY_W-1:0] probe_key_q;
  logic [FILT_W-1:0] filt_idx;
  logic [HASH_W-1:0] bucket;
  logic             filt_hit;
  logic             accept, build_acc, probe_acc;
  logic [PTR_W-1:0] head;
  logic [KEY_W-1:0] rd_key;
  logic [ROW_W-1:0] rd_row;
  logic [PTR_W-1:0] rd_next;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o && !clear_i;
  assign build_acc  = accept && !phase_i;
  assign probe_acc  = accept && phase_i;

  hjf_hash #(.KEY_W(KEY_W), .FILT_W(FILT_W), .HASH_W(HASH_W)) u_hash (
    .key_i      (in_key_i),
    .filt_idx_o (filt_idx),
    .bucket_o   (bucket)
  );

  hjf_bitvec #(.FILT_W(FILT_W)) u_bitvec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .set_i   (build_acc),
    .idx_i   (filt_idx),
    .hit_o   (filt_hit)
  );

  hjf_table #(
    .KEY_W(KEY_W), .ROW_W(ROW_W), .HASH_W(HASH_W), .DEPTH(DEPTH)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .ins_i     (build_acc),
    .bucket_i  (bucket),
    .key_i     (in_key_i),
    .row_i     (in_row_i),
    .head_o    (head),
    .rd_ptr_i  (ptr_q),
    .rd_key_o  (rd_key),
    .rd_row_o  (rd_row),
    .rd_next_o (rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      ptr_q         <= NULL_PTR;
      probe_key_q   <= '0;
      match_valid_o <= 1'b0;
      match_row_o   <= '0;
    end else if (clear_i) begin
      state_q       <= ST_IDLE;
      ptr_q         <= NULL_PTR;
      match_valid_o <= 1'b0;
    end else begin
      match_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          // filter miss or empty bucket: no walk
          if (probe_acc && filt_hit && (head != NULL_PTR)) begin
            state_q     <= ST_WALK;
            ptr_q       <= head;
            probe_key_q <= in_key_i;
          end
        end
        ST_WALK: begin
          if (rd_key == probe_key_q) begin
            match_valid_o <= 1'b1;
            match_row_o   <= rd_row;
          end
          ptr_q <= rd_next;
          if (rd_next == NULL_PTR) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hjf_checker.sv
module hjf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic phase_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic match_valid_o,
  input logic filt_hit_i
);
  a_r1_ready_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rst_ni)) |-> (in_ready_o && !match_valid_o));

  a_r3_build_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !phase_i && !clear_i) |=> in_ready_o);

  a_r4_drop_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && phase_i && !filt_hit_i && !clear_i)
      |=> (in_ready_o && !match_valid_o));

  a_r6_match_from_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_o |-> $past(!in_ready_o));

  a_r9_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (in_ready_o && !match_valid_o));
endmodule

bind hjoin_filter hjf_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .phase_i       (phase_i),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .match_valid_o (match_valid_o),
  .filt_hit_i    (filt_hit)
);

// File: tb/hjoin_filter_test.sv
`timescale 1ns/1ps
module hjoin_filter_test;
  localparam int KEY_W = 16, ROW_W = 16, FILT_W = 6, HASH_W = 4, DEPTH = 32;

  logic clk = 1'b0, rst_ni = 1'b0, clear_i = 1'b0, phase_i = 1'b0, in_valid_i = 1'b0;
  logic [KEY_W-1:0] in_key_i = '0;
  logic [ROW_W-1:0] in_row_i = '0;
  logic in_ready_o, match_valid_o;
  logic [ROW_W-1:0] match_row_o;

  always #2 clk = ~clk;

  hjoin_filter #(.KEY_W(KEY_W), .ROW_W(ROW_W), .FILT_W(FILT_W), .HASH_W(HASH_W),
                 .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .phase_i(phase_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_key_i(in_key_i),
    .in_row_i(in_row_i), .match_valid_o(match_valid_o), .match_row_o(match_row_o));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [KEY_W-1:0] m_key [DEPTH];
  logic [ROW_W-1:0] m_row [DEPTH];
  int m_cnt = 0;
  bit m_bits [64];

  function automatic int fold(input logic [KEY_W-1:0] k);
    int v = int'(k);
    return (v ^ (v >> 6) ^ (v >> 12)) & 63;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0;
    for (int i = 0; i < 64; i++) m_bits[i] = 0;
  endtask

  task automatic do_build(input logic [KEY_W-1:0] k, input logic [ROW_W-1:0] r);
    in_valid_i = 1; phase_i = 0; in_key_i = k; in_row_i = r;
    chk(in_ready_o == 1'b1, "R3 build ready", int'(in_ready_o), 1);
    @(negedge clk);
    m_bits[fold(k)] = 1;
    if (m_cnt < DEPTH) begin
      m_key[m_cnt] = k; m_row[m_cnt] = r; m_cnt++;
    end
  endtask

  task automatic go_idle();
    in_valid_i = 0;
    @(negedge clk);
  endtask

  task automatic do_probe(input logic [KEY_W-1:0] k, input string tag);
    int f, exp_stall, cnt, nm;
    logic [ROW_W-1:0] exp_rows [$];
    logic [ROW_W-1:0] got_rows [$];
    string req;
    f = fold(k);
    exp_stall = 0;
    if (m_bits[f])
      for (int i = 0; i < m_cnt; i++)
        if ((fold(m_key[i]) & 15) == (f & 15)) exp_stall++;
    for (int i = m_cnt - 1; i >= 0; i--)
      if (m_bits[f] && m_key[i] == k) exp_rows.push_back(m_row[i]);
    if (tag != "") req = tag;
    else if (!m_bits[f]) req = "R4";
    else if (exp_rows.size() == 0) req = "R7";
    else req = "R6";
    in_valid_i = 1; phase_i = 1; in_key_i = k;
    @(negedge clk);
    in_valid_i = 0;
    cnt = 0;
    for (int g = 0; g < 100; g++) begin
      if (match_valid_o) got_rows.push_back(match_row_o);
      if (in_ready_o) break;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_stall, {req, " R5 stall cycles"}, cnt, exp_stall);
    nm = got_rows.size();
    chk(nm == exp_rows.size(), {req, " match count"}, nm, exp_rows.size());
    for (int i = 0; i < nm && i < exp_rows.size(); i++)
      chk(got_rows[i] == exp_rows[i], {req, " match row order"},
          int'(got_rows[i]), int'(exp_rows[i]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready_o == 1'b1, "R1 ready after reset", int'(in_ready_o), 1);
    chk(match_valid_o == 1'b0, "R1 no match after reset", int'(match_valid_o), 0);
    for (int k = 0; k < 64; k++) do_probe(KEY_W'(k * 37), "R1");

    // R2: single key, sweep every filter index
    do_build(16'hBEEF, 16'h0BEE);
    go_idle();
    for (int k = 0; k < 64; k++) do_probe(KEY_W'(k), "R2");
    do_probe(16'hBEEF, "R2");

    // R3, R6, R7: back-to-back build with duplicates and collisions
    clear_i = 1; @(negedge clk); clear_i = 0; model_clear();
    for (int i = 0; i < 24; i++) do_build(KEY_W'((i % 8) * 16'h0101), ROW_W'(16'h1000 + i));
    do_build(16'h0001, 16'h2001);
    do_build(16'h0203, 16'h2002);
    go_idle();
    for (int i = 0; i < 8; i++) do_probe(KEY_W'(i * 16'h0101), "");
    do_probe(16'h0040, "R7");
    do_probe(16'h0011, "");
    for (int k = 0; k < 64; k++) do_probe(KEY_W'(k * 16'h0103), "");

    // R9: clear during a walk, with a build row offered in the same cycle
    in_valid_i = 1; phase_i = 1; in_key_i = 16'h0000;
    @(negedge clk);
    chk(in_ready_o == 1'b0, "R9 walk started", int'(in_ready_o), 0);
    clear_i = 1; phase_i = 0; in_key_i = 16'h7777; in_row_i = 16'h0777;
    @(negedge clk);
    clear_i = 0; in_valid_i = 0;
    model_clear();
    chk(in_ready_o == 1'b1, "R9 ready after clear", int'(in_ready_o), 1);
    chk(match_valid_o == 1'b0, "R9 no match after clear", int'(match_valid_o), 0);
    do_probe(16'h7777, "R9");
    do_probe(16'h0000, "R9");

    // R10: input offered during a walk is ignored
    for (int i = 0; i < 3; i++) do_build(16'h0505, ROW_W'(16'h3000 + i));
    go_idle();
    in_valid_i = 1; phase_i = 1; in_key_i = 16'h0505;
    @(negedge clk);
    phase_i = 0; in_key_i = 16'h0A0A; in_row_i = 16'h0AAA;
    @(negedge clk);
    in_valid_i = 0;
    for (int g = 0; g < 10; g++) if (!in_ready_o) @(negedge clk);
    do_probe(16'h0A0A, "R10");
    do_probe(16'h0505, "R10");

    // R8: full table
    clear_i = 1; @(negedge clk); clear_i = 0; model_clear();
    for (int i = 0; i < DEPTH; i++) do_build(KEY_W'(16'h1000 + i), ROW_W'(16'h4000 + i));
    do_build(16'h2000, 16'h5000);
    do_build(16'h1005, 16'h5001);
    go_idle();
    do_probe(16'h2000, "R8");
    do_probe(16'h1005, "R8");
    do_probe(16'h101F, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule